// File: doc/BRIEF.md
# Serial/Quad Memory Command Front-End

This block sits on the device side of a serial memory link. It oversamples chip select, the serial clock and four data lines with its own system clock. It then assembles an 8-bit opcode from the host. In single-line mode the opcode arrives one bit per serial clock on line 0. In quad-instruction mode it arrives as two nibbles on lines 3..0. Recognised opcodes raise a one-cycle strobe with a command identifier for downstream memory logic. The block itself keeps two flags: a write-enable latch and the quad-instruction mode flag. Both are visible in a status byte that the host can read back.

The quad read and quad write commands are followed by address, dummy and data phases. The front-end only walks through these phases and reports which one is active; it does not move any data. Mode and latch changes requested by a command take effect only when chip select returns high at the end of a complete frame.

The controller is a single state machine with these states: IDLE (deselected), OPCODE (collecting opcode units), STATUS (returning the status byte), ADDR (6 address nibbles), DUMMY (dummy clocks), DATA (data beats until deselect) and HOLD (rest of the frame ignored, command pending). The transitions are:
- IDLE to OPCODE when chip select is low.
- OPCODE to STATUS on a completed status-read opcode.
- OPCODE to ADDR on a completed quad read or quad write opcode.
- OPCODE to HOLD on any other completed opcode.
- ADDR to DUMMY (quad read) or to DATA (quad write) on the last address nibble.
- DUMMY to DATA on the last dummy clock.
- Any state to IDLE when chip select goes high.

Top module: `qf_cmd_frontend`

## Requirements
- R1: After reset, quad_mode and wr_en_latch are 0, io_oe is 0000, cmd_valid is 0 and phase is 0 (IDLE).
- R2: In single-line mode, the opcode is taken on 8 rising serial-clock edges from io_in[0], most significant bit first. A recognised opcode raises cmd_valid for one clock with cmd_id coded as follows: WREN=1, WRDI=2, RDSR=3, QREAD=4, QWRITE=5, QEN=6, QDIS=7.
- R3: In quad-instruction mode, the opcode is taken on 2 rising edges from io_in[3:0], upper nibble first.
- R4: Opcode 38h in single-line mode sets quad_mode when chip select rises, not before. Status bit 6 reflects quad_mode.
- R5: Opcode FFh in quad mode clears quad_mode at the end of the frame. In single-line mode FFh is ignored.
- R6: Opcode 06h sets and 04h clears wr_en_latch in either mode, at the end of the frame. Status bit 1 reflects the latch. All other status bits are 0.
- R7: Opcode 05h in single-line mode drives the status byte on io_out[1], MSB first, one bit per falling edge, with io_oe=0010. The byte repeats while chip select stays low.
- R8: Opcode 05h in quad mode drives the status byte on io_out[3:0], upper nibble first, one nibble per falling edge, with io_oe=1111. The two nibbles repeat.
- R9: If chip select rises before a full opcode has been taken, no strobe occurs and no flag changes.
- R10: Unrecognised opcodes give no strobe and put the block in HOLD (phase 6). Later bits in the same frame are ignored. This covers 38h in quad mode and EBh, 12h or FFh in single-line mode.
- R11: Opcode EBh in quad mode passes through ADDR (phase 3) for 6 clocks, then DUMMY (phase 4) for 6 clocks, then DATA (phase 5) until deselect.
- R12: Opcode 12h in quad mode passes through ADDR for 6 clocks, then goes directly to DATA.
- R13: cmd_valid is a single-cycle pulse, raised exactly once per completed recognised opcode, and only for such opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from host, active low |
| sck | input | 1 | Serial clock from host |
| io_in | input | 4 | Data lines as driven by the host |
| io_out | output | 4 | Data lines as driven by the block |
| io_oe | output | 4 | Per-line output enable |
| cmd_valid | output | 1 | One-cycle decoded-command strobe |
| cmd_id | output | 3 | Identifier of the last completed opcode |
| phase | output | 3 | Current state: 0 IDLE, 1 OPCODE, 2 STATUS, 3 ADDR, 4 DUMMY, 5 DATA, 6 HOLD |
| quad_mode | output | 1 | Quad-instruction mode flag |
| wr_en_latch | output | 1 | Write-enable latch |

## Verification
The hardest situations to reach are the ones where a command must not act. Examples are a frame cut short partway through an opcode, or an opcode that is valid only in the other mode. The only evidence is the absence of a strobe and unchanged flags. The stimulus first drives the flags away from reset by setting the latch and entering quad mode. It then sends truncated frames, wrong-mode opcodes and an unrecognised opcode followed by a valid one in the same frame. Afterwards it reads back the status byte and checks the strobe queue.

// File: rtl/qf_pkg.sv
package qf_pkg;

    localparam int LANES   = 4;
    localparam int OP_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_STATUS = 3'd2,
        ST_ADDR   = 3'd3,
        ST_DUMMY  = 3'd4,
        ST_DATA   = 3'd5,
        ST_HOLD   = 3'd6
    } fe_state_t;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_WREN   = 3'd1,
        CMD_WRDI   = 3'd2,
        CMD_RDSR   = 3'd3,
        CMD_QREAD  = 3'd4,
        CMD_QWRITE = 3'd5,
        CMD_QEN    = 3'd6,
        CMD_QDIS   = 3'd7
    } cmd_id_t;

    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_WRDI   = 8'h04;
    localparam logic [7:0] OPC_RDSR   = 8'h05;
    localparam logic [7:0] OPC_QREAD  = 8'hEB;
    localparam logic [7:0] OPC_QWRITE = 8'h12;
    localparam logic [7:0] OPC_QEN    = 8'h38;
    localparam logic [7:0] OPC_QDIS   = 8'hFF;

    // Mode-dependent opcode decode
    function automatic cmd_id_t decode_op(input logic [7:0] op, input logic quad);
        cmd_id_t id;
        case (op)
            OPC_WREN:   id = CMD_WREN;
            OPC_WRDI:   id = CMD_WRDI;
            OPC_RDSR:   id = CMD_RDSR;
            OPC_QEN:    id = quad ? CMD_NONE : CMD_QEN;
            OPC_QDIS:   id = quad ? CMD_QDIS : CMD_NONE;
            OPC_QREAD:  id = quad ? CMD_QREAD : CMD_NONE;
            OPC_QWRITE: id = quad ? CMD_QWRITE : CMD_NONE;
            default:    id = CMD_NONE;
        endcase
        return id;
    endfunction

endpackage

// File: rtl/qf_pin_sync.sv
module qf_pin_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RESET_VAL[b]}};
                end else begin
                    chain <= {chain[STAGES-2:0], d[b]};
                end
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/qf_opcode_rx.sv
module qf_opcode_rx
    import qf_pkg::*;
#(
    parameter int OPB = OP_BITS,
    parameter int LN  = LANES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           sample,
    input  logic           quad,
    input  logic [LN-1:0]  io,
    output logic           done,
    output logic [OPB-1:0] opcode
);

    localparam int CNT_W       = $clog2(OPB);
    localparam int SINGLE_LAST = OPB - 1;
    localparam int QUAD_LAST   = (OPB / LN) - 1;

    logic [OPB-1:0]   sr;
    logic [OPB-1:0]   sr_next;
    logic [CNT_W-1:0] cnt;
    logic             last;

    always_comb begin
        if (quad) begin
            sr_next = {sr[OPB-LN-1:0], io};
            last    = (cnt == CNT_W'(QUAD_LAST));
        end else begin
            sr_next = {sr[OPB-2:0], io[0]};
            last    = (cnt == CNT_W'(SINGLE_LAST));
        end
    end

    assign done   = sample && last;
    assign opcode = sr_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (clear) begin
            sr  <= '0;
            cnt <= '0;
        end else if (sample) begin
            sr  <= sr_next;
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/qf_status_tx.sv
module qf_status_tx
    import qf_pkg::*;
#(
    parameter int BYTE_W    = OP_BITS,
    parameter int LN        = LANES,
    parameter int DOUT_LANE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              quad,
    input  logic              shift,
    input  logic [BYTE_W-1:0] stat,
    output logic [LN-1:0]     io_out,
    output logic [LN-1:0]     io_oe
);

    localparam int PTR_W  = $clog2(BYTE_W);
    localparam int NIBS   = BYTE_W / LN;
    localparam int NIB_W  = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [LN-1:0] SINGLE_OE = LN'(1) << DOUT_LANE;

    logic [PTR_W-1:0] ptr;
    logic [NIB_W-1:0] nib_idx;
    logic [LN-1:0]    unit_val;
    logic [LN-1:0]    unit_oe;

    assign nib_idx = NIB_W'(ptr % PTR_W'(NIBS));

    always_comb begin
        if (quad) begin
            unit_val = stat[(NIBS - 1 - int'(nib_idx)) * LN +: LN];
            unit_oe  = '1;
        end else begin
            unit_val = '0;
            unit_val[DOUT_LANE] = stat[BYTE_W - 1 - int'(ptr)];
            unit_oe  = SINGLE_OE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            io_out <= '0;
            io_oe  <= '0;
        end else if (!active) begin
            ptr    <= '0;
            io_out <= '0;
            io_oe  <= '0;
        end else if (shift) begin
            io_out <= unit_val;
            io_oe  <= unit_oe;
            ptr    <= ptr + PTR_W'(1);
        end
    end

endmodule

// File: rtl/qf_cmd_frontend.sv
module qf_cmd_frontend
    import qf_pkg::*;
#(
    parameter int ADDR_NIBBLES = 6,
    parameter int DUMMY_CYCLES = 6,
    parameter int SYNC_STAGES  = 2,
    parameter int QUAD_BIT     = 6,
    parameter int WEL_BIT      = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic [3:0] io_in,
    output logic [3:0] io_out,
    output logic [3:0] io_oe,
    output logic       cmd_valid,
    output logic [2:0] cmd_id,
    output logic [2:0] phase,
    output logic       quad_mode,
    output logic       wr_en_latch
);

    localparam int PH_MAX = (ADDR_NIBBLES > DUMMY_CYCLES) ? ADDR_NIBBLES : DUMMY_CYCLES;
    localparam int PH_W   = $clog2(PH_MAX + 1);

    // Pin synchronisation
    logic             cs_n_s;
    logic             sck_s;
    logic [LANES-1:0] io_s;
    logic             cs_n_d;
    logic             sck_d;

    qf_pin_sync #(
        .WIDTH    (2),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(2'b01)
    ) ctl_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sck, cs_n}),
        .q    ({sck_s, cs_n_s})
    );

    qf_pin_sync #(
        .WIDTH    (LANES),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL('0)
    ) dat_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (io_in),
        .q    (io_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_d <= 1'b1;
            sck_d  <= 1'b0;
        end else begin
            cs_n_d <= cs_n_s;
            sck_d  <= sck_s;
        end
    end

    logic cs_act;
    logic sck_rise;
    logic sck_fall;
    logic frame_end;

    assign cs_act    = ~cs_n_s;
    assign sck_rise  = sck_s & ~sck_d;
    assign sck_fall  = ~sck_s & sck_d;
    assign frame_end = cs_n_s & ~cs_n_d;

    // State and flags
    fe_state_t       state_q;
    fe_state_t       state_d;
    cmd_id_t         cmd_id_q;
    logic            cmd_valid_q;
    logic            quad_q;
    logic            wel_q;
    logic [PH_W-1:0] ph_cnt;

    // Opcode capture
    logic         op_done;
    logic [7:0]   op_byte;
    cmd_id_t      op_dec;
    logic         op_sample;

    assign op_sample = sck_rise && cs_act && (state_q == ST_OPCODE);

    qf_opcode_rx #(
        .OPB(OP_BITS),
        .LN (LANES)
    ) op_rx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_OPCODE),
        .sample(op_sample),
        .quad  (quad_q),
        .io    (io_s),
        .done  (op_done),
        .opcode(op_byte)
    );

    assign op_dec = decode_op(op_byte, quad_q);

    logic addr_last;
    logic dummy_last;

    assign addr_last  = sck_rise && (ph_cnt == PH_W'(ADDR_NIBBLES - 1));
    assign dummy_last = sck_rise && (ph_cnt == PH_W'(DUMMY_CYCLES - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!cs_act) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: begin
                    if (op_done) begin
                        case (op_dec)
                            CMD_RDSR:              state_d = ST_STATUS;
                            CMD_QREAD, CMD_QWRITE: state_d = ST_ADDR;
                            default:               state_d = ST_HOLD;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (addr_last) begin
                        state_d = (cmd_id_q == CMD_QREAD) ? ST_DUMMY : ST_DATA;
                    end
                end
                ST_DUMMY: begin
                    if (dummy_last) begin
                        state_d = ST_DATA;
                    end
                end
                ST_STATUS: state_d = ST_STATUS;
                ST_DATA:   state_d = ST_DATA;
                ST_HOLD:   state_d = ST_HOLD;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs, phase counter and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid_q <= 1'b0;
            cmd_id_q    <= CMD_NONE;
            quad_q      <= 1'b0;
            wel_q       <= 1'b0;
            ph_cnt      <= '0;
        end else begin
            cmd_valid_q <= 1'b0;
            if (op_done) begin
                cmd_id_q    <= op_dec;
                cmd_valid_q <= (op_dec != CMD_NONE);
            end

            if (state_d != state_q) begin
                ph_cnt <= '0;
            end else if (sck_rise && (state_q == ST_ADDR || state_q == ST_DUMMY)) begin
                ph_cnt <= ph_cnt + PH_W'(1);
            end

            if (frame_end && state_q == ST_HOLD) begin
                case (cmd_id_q)
                    CMD_WREN: wel_q  <= 1'b1;
                    CMD_WRDI: wel_q  <= 1'b0;
                    CMD_QEN:  quad_q <= 1'b1;
                    CMD_QDIS: quad_q <= 1'b0;
                    default:  ;
                endcase
            end
        end
    end

    // Status byte and its return path
    logic [7:0] stat_byte;

    always_comb begin
        stat_byte           = '0;
        stat_byte[QUAD_BIT] = quad_q;
        stat_byte[WEL_BIT]  = wel_q;
    end

    qf_status_tx #(
        .BYTE_W   (OP_BITS),
        .LN       (LANES),
        .DOUT_LANE(1)
    ) stat_tx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .active(state_q == ST_STATUS),
        .quad  (quad_q),
        .shift (sck_fall),
        .stat  (stat_byte),
        .io_out(io_out),
        .io_oe (io_oe)
    );

    assign cmd_valid   = cmd_valid_q;
    assign cmd_id      = cmd_id_q;
    assign phase       = state_q;
    assign quad_mode   = quad_q;
    assign wr_en_latch = wel_q;

endmodule

// File: rtl/qf_cmd_frontend_chk.sv
module qf_cmd_frontend_chk
    import qf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_act,
    input fe_state_t  state,
    input logic       cmd_valid,
    input logic [2:0] cmd_id,
    input logic       quad_mode,
    input logic       wr_en_latch,
    input logic [3:0] io_oe
);

    // R13
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R13
    cmd_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_id != CMD_NONE));

    // R4
    quad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_mode != $past(quad_mode)) |-> !cs_act);

    // R6
    wel_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_latch != $past(wr_en_latch)) |-> !cs_act);

    // R7
    oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000) || (io_oe == 4'b0010) || (io_oe == 4'b1111));

    // R8
    oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != 4'b0000) |-> ($past(state) == ST_STATUS));

    // R11
    quad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_id == CMD_QREAD || cmd_id == CMD_QWRITE)) |-> quad_mode);

endmodule

bind qf_cmd_frontend qf_cmd_frontend_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .state      (state_q),
    .cmd_valid  (cmd_valid),
    .cmd_id     (cmd_id),
    .quad_mode  (quad_mode),
    .wr_en_latch(wr_en_latch),
    .io_oe      (io_oe)
);

// File: tb/qf_cmd_frontend_tb_top.sv
`timescale 1ns/1ps
module qf_cmd_frontend_tb_top;
    import qf_pkg::*;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic [3:0] io_in = 4'h0;
    logic [3:0] io_out;
    logic [3:0] io_oe;
    logic       cmd_valid;
    logic [2:0] cmd_id;
    logic [2:0] phase;
    logic       quad_mode;
    logic       wr_en_latch;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [2:0] exp_q[$];

    always #4 clk = ~clk;

    qf_cmd_frontend dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck        (sck),
        .io_in      (io_in),
        .io_out     (io_out),
        .io_oe      (io_oe),
        .cmd_valid  (cmd_valid),
        .cmd_id     (cmd_id),
        .phase      (phase),
        .quad_mode  (quad_mode),
        .wr_en_latch(wr_en_latch)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_cycle(input logic [3:0] d, output logic [3:0] o, output logic [3:0] oe);
        io_in = d;
        wait_clk(H);
        o  = io_out;
        oe = io_oe;
        sck = 1'b1;
        wait_clk(H);
        sck = 1'b0;
    endtask

    task automatic frame_start();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic frame_stop();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(H);
    endtask

    task automatic send_op(input logic [7:0] op, input bit quad);
        logic [3:0] o, oe;
        if (quad) begin
            sck_cycle(op[7:4], o, oe);
            sck_cycle(op[3:0], o, oe);
        end else begin
            for (int i = 7; i >= 0; i--) sck_cycle({3'b000, op[i]}, o, oe);
        end
    endtask

    task automatic command(input logic [7:0] op, input bit quad, input cmd_id_t exp);
        if (exp != CMD_NONE) exp_q.push_back(exp);
        frame_start();
        send_op(op, quad);
        frame_stop();
    endtask

    task automatic read_status(input bit quad, input logic [7:0] exp, input int nbytes, input string req);
        logic [3:0] o, oe;
        exp_q.push_back(CMD_RDSR);
        frame_start();
        send_op(OPC_RDSR, quad);
        if (quad) begin
            for (int k = 0; k < nbytes * 2; k++) begin
                sck_cycle(4'h0, o, oe);
                check({req, " nibble"}, o, (k % 2 == 0) ? exp[7:4] : exp[3:0]);
                check({req, " oe"}, oe, 4'b1111);
            end
        end else begin
            for (int k = 0; k < nbytes * 8; k++) begin
                sck_cycle(4'h0, o, oe);
                check({req, " bit"}, o, {2'b00, exp[7 - (k % 8)], 1'b0});
                check({req, " oe"}, oe, 4'b0010);
            end
        end
        frame_stop();
        check({req, " oe released"}, io_oe, 0);
    endtask

    // Monitor: pops expected command ids as strobes appear (R2 R3 R13)
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0) begin
                check("R13 unexpected strobe", cmd_id, 0);
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                check("R2/R3 cmd_id", cmd_id, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] o, oe;
        wait_clk(5);
        // R1 reset values
        check("R1 quad_mode", quad_mode, 0);
        check("R1 wel", wr_en_latch, 0);
        check("R1 oe", io_oe, 0);
        check("R1 cmd_valid", cmd_valid, 0);
        check("R1 phase", phase, 0);
        rst_n = 1'b1;
        wait_clk(5);
        check("R1 phase after release", phase, 0);

        // R7 single-line status, all zero, repeated
        read_status(1'b0, 8'h00, 2, "R7 status reset");

        // R2 R6 WREN in single-line mode
        command(OPC_WREN, 1'b0, CMD_WREN);
        check("R6 wel set", wr_en_latch, 1);
        read_status(1'b0, 8'h02, 2, "R7 status wel");

        // R9 aborted single-line frame (first 5 bits of WRDI)
        frame_start();
        for (int i = 0; i < 5; i++) sck_cycle(4'h0, o, oe);
        check("R9 phase opcode", phase, 1);
        frame_stop();
        check("R9 wel kept", wr_en_latch, 1);
        check("R9 phase idle", phase, 0);

        // R10 unrecognised then a valid opcode in the same frame
        frame_start();
        send_op(OPC_QREAD, 1'b0);
        check("R10 phase hold", phase, 6);
        send_op(OPC_QEN, 1'b0);
        frame_stop();
        check("R10 quad unchanged", quad_mode, 0);

        // R5 FFh ignored in single-line mode
        command(OPC_QDIS, 1'b0, CMD_NONE);
        check("R5 single FF ignored", quad_mode, 0);

        // R4 enter quad mode, effective only at deselect
        exp_q.push_back(CMD_QEN);
        frame_start();
        send_op(OPC_QEN, 1'b0);
        wait_clk(H);
        check("R4 quad before deselect", quad_mode, 0);
        frame_stop();
        check("R4 quad set", quad_mode, 1);

        // R3 R8 quad status read
        read_status(1'b1, 8'h42, 2, "R8 status quad");

        // R6 WRDI in quad mode
        command(OPC_WRDI, 1'b1, CMD_WRDI);
        check("R6 wel cleared", wr_en_latch, 0);
        read_status(1'b1, 8'h40, 1, "R8 status quad nowel");

        // R10 38h in quad mode gives no strobe
        command(OPC_QEN, 1'b1, CMD_NONE);
        check("R10 quad kept", quad_mode, 1);

        // R9 aborted quad frame (upper nibble of WREN)
        frame_start();
        sck_cycle(4'h0, o, oe);
        frame_stop();
        check("R9 quad abort wel", wr_en_latch, 0);

        // R11 quad read phases
        exp_q.push_back(CMD_QREAD);
        frame_start();
        send_op(OPC_QREAD, 1'b1);
        check("R11 addr phase", phase, 3);
        for (int i = 0; i < 5; i++) sck_cycle(4'h0, o, oe);
        check("R11 addr still", phase, 3);
        sck_cycle(4'h0, o, oe);
        check("R11 dummy phase", phase, 4);
        for (int i = 0; i < 5; i++) sck_cycle(4'h0, o, oe);
        check("R11 dummy still", phase, 4);
        sck_cycle(4'h0, o, oe);
        check("R11 data phase", phase, 5);
        for (int i = 0; i < 3; i++) sck_cycle(4'h0, o, oe);
        check("R11 data stays", phase, 5);
        frame_stop();
        check("R11 idle after", phase, 0);

        // R12 quad write phases
        exp_q.push_back(CMD_QWRITE);
        frame_start();
        send_op(OPC_QWRITE, 1'b1);
        for (int i = 0; i < 5; i++) sck_cycle(4'h0, o, oe);
        check("R12 addr still", phase, 3);
        sck_cycle(4'h0, o, oe);
        check("R12 data phase", phase, 5);
        frame_stop();

        // R5 leave quad mode
        command(OPC_QDIS, 1'b1, CMD_QDIS);
        check("R5 quad cleared", quad_mode, 0);
        read_status(1'b0, 8'h00, 1, "R5 status single");

        wait_clk(10);
        check("R13 queue drained", exp_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule